// File: doc/BRIEF.md
# Interleaved Class-4 Partial-Response Viterbi Detector

This block is a maximum-likelihood sequence detector for a read channel shaped to the class-4 partial response, whose noiseless output is `LEVEL * (a[n] - a[n-2])` for binary data `a`. A full-rate 4-state trellis is not built. The block splits the sample stream by index parity into two independent 2-state dicode (1 − D) detectors. Samples with an even index go to lane 0 and samples with an odd index go to lane 1. Each lane therefore advances once every two accepted samples, so one delay step in a lane spans two symbol periods of the channel. Each lane has a branch-metric unit, two add-compare-select cells and a register-exchange survivor array `DEPTH` entries deep.

An output switch follows the same parity and takes the oldest survivor bit from the lane that the current sample feeds. Because it does so, the decisions leave in the original bit order. Each lane takes that bit from the state whose path metric is smaller, and a tie picks state 0. Path metrics are unsigned. After every step the smaller metric is subtracted from both, so one of them is always zero.

A small controller has two states. In `ST_FILL` it counts accepted samples. It takes the transition `FILL_DONE` into `ST_STREAM` once `2*DEPTH` samples have been accepted, and from then on it marks every accepted sample's output as valid. The transition `RESTART` returns it to `ST_FILL` from either state on a synchronous reset. Cycles without `in_valid` change nothing.

Top module: `pr4_ilv_viterbi`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes low at that edge. Both lane metrics are cleared to zero, the survivors are emptied and the switch returns to lane 0.
- R2: Accepted samples alternate between the lanes, starting with lane 0 after reset. Exactly one lane advances per accepted sample. An input whose even-indexed bits are all 1 and odd-indexed bits all 0 is returned in that same interleaved order.
- R3: For the first `2*DEPTH` (16) accepted samples after reset, `out_valid` stays low. From accepted sample number 16 (counting from 0) onward, `out_valid` is high in the cycle after each accepted sample.
- R4: With noiseless input, the `out_bit` that accompanies accepted sample n (n ≥ 16) equals data bit a[n-16]. Bits a[-1] and a[-2] are taken as 0, and the sample is `LEVEL*(a[n]-a[n-2])` with `LEVEL` = 24.
- R5: With bounded additive noise of at most ±3 per sample, the decisions still equal a[n-16].
- R6: A cycle with `in_valid` low produces `out_valid` low on the next cycle. It does not advance either lane or the switch, whatever value is on `in_sample`.
- R7: Branch metrics are squared distances to the ideal branch outputs −LEVEL, 0 and +LEVEL, saturated at 2^MW−1. After every lane step the smaller metric is zero and no normalized metric exceeds 2^MW−1.
- R8: On ties, the compare keeps the path from state 0, and the output takes state 0 as the best state. An all-zero input therefore decodes to all zeros.
- R9: A reset applied in the middle of a stream restarts the fill count. The next 16 accepted samples give `out_valid` low, and decoding then resumes correctly on the new stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` in this cycle |
| in_sample | input | SW (8) | Equalized signed channel sample |
| out_valid | output | 1 | `out_bit` carries a decision this cycle |
| out_bit | output | 1 | Detected data bit, delayed by 2*DEPTH accepted samples |

## Verification
The assertions are checked on every cycle. They cover these properties:
- Exactly one lane steps per accepted sample.
- The lanes alternate.
- Metrics hold still on idle cycles.
- One metric is zero after each step, and the normalized metric never overflows.
- `out_valid` only follows an accepted sample in `ST_STREAM`.

Whether the decisions are the right bits, in the right order and after the right fill, is shown only by the bench scenarios. These drive all-zero, all-one and parity-patterned streams, long noiseless and noisy random streams with idle gaps, and a reset in the middle of a stream, and they compare each output against the generated data.

// File: rtl/pr4_vit_pkg.sv
package pr4_vit_pkg;

    typedef enum logic {
        ST_FILL   = 1'b0,
        ST_STREAM = 1'b1
    } ctl_state_t;

    // Ideal noiseless dicode output for a branch leaving state s with new bit b
    function automatic int ideal_out(input int s, input int b, input int level);
        return (b - s) * level;
    endfunction

endpackage

// File: rtl/pr4_bmu.sv
module pr4_bmu #(
    parameter int SW    = 8,
    parameter int MW    = 12,
    parameter int LEVEL = 24
) (
    input  logic signed [SW-1:0]      sample,
    output logic        [3:0][MW-1:0] bm      // index {from_state, new_bit}
);
    import pr4_vit_pkg::*;

    localparam int DW = SW + 2;
    localparam int QW = 2 * DW;
    localparam logic [QW-1:0] SAT = QW'((64'd1 << MW) - 64'd1);

    logic signed [DW-1:0] samp_x;
    assign samp_x = DW'(sample);

    for (genvar k = 0; k < 4; k++) begin : g_branch
        localparam int REF = ideal_out(k >> 1, k & 1, LEVEL);
        logic signed [DW-1:0] diff;
        logic signed [QW-1:0] sq;
        logic        [QW-1:0] sq_u;
        always_comb begin
            diff = samp_x - DW'(REF);
            sq   = QW'(diff) * QW'(diff);
            sq_u = sq;
            bm[k] = (sq_u > SAT) ? SAT[MW-1:0] : sq_u[MW-1:0];
        end
    end

endmodule

// File: rtl/pr4_dicode_lane.sv
module pr4_dicode_lane #(
    parameter int SW    = 8,
    parameter int MW    = 12,
    parameter int DEPTH = 8,
    parameter int LEVEL = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic signed [SW-1:0] sample,
    output logic                 oldest
);
    localparam int AW = MW + 1;

    logic [3:0][MW-1:0] bm;
    logic [MW-1:0]      pm0, pm1;
    logic [DEPTH-1:0]   sv0, sv1;
    logic [AW-1:0]      c00, c10, c01, c11, n0, n1, nmin, d0, d1;
    logic               from1_to0, from1_to1;
    logic [DEPTH-1:0]   keep0, keep1;

    pr4_bmu #(.SW(SW), .MW(MW), .LEVEL(LEVEL)) u_bmu (
        .sample (sample),
        .bm     (bm)
    );

    // Add-compare-select; ties keep the path from state 0
    always_comb begin
        c00 = {1'b0, pm0} + {1'b0, bm[0]};
        c10 = {1'b0, pm1} + {1'b0, bm[2]};
        c01 = {1'b0, pm0} + {1'b0, bm[1]};
        c11 = {1'b0, pm1} + {1'b0, bm[3]};
        from1_to0 = (c10 < c00);
        from1_to1 = (c11 < c01);
        n0   = from1_to0 ? c10 : c00;
        n1   = from1_to1 ? c11 : c01;
        nmin = (n1 < n0) ? n1 : n0;
        d0   = n0 - nmin;
        d1   = n1 - nmin;
        keep0 = from1_to0 ? sv1 : sv0;
        keep1 = from1_to1 ? sv1 : sv0;
        oldest = (pm1 < pm0) ? sv1[DEPTH-1] : sv0[DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm0 <= '0;
            pm1 <= '0;
            sv0 <= '0;
            sv1 <= '0;
        end else if (step) begin
            pm0 <= d0[MW-1:0];
            pm1 <= d1[MW-1:0];
            sv0 <= {keep0[DEPTH-2:0], 1'b0};
            sv1 <= {keep1[DEPTH-2:0], 1'b1};
        end
    end

    assert_metric_floor_R7: assert property (@(posedge clk) disable iff (rst)
        step |=> (pm0 == '0 || pm1 == '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        step |-> (d0[MW] == 1'b0 && d1[MW] == 1'b0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(pm0) && $stable(pm1) && $stable(sv0) && $stable(sv1)));

endmodule

// File: rtl/pr4_ilv_viterbi.sv
module pr4_ilv_viterbi #(
    parameter int SW    = 8,
    parameter int MW    = 12,
    parameter int DEPTH = 8,
    parameter int LEVEL = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_sample,
    output logic                 out_valid,
    output logic                 out_bit
);
    import pr4_vit_pkg::*;

    localparam int FILL_N = 2 * DEPTH;
    localparam int CW     = $clog2(FILL_N + 1);

    ctl_state_t    state, state_nx;
    logic [CW-1:0] fill_cnt;
    logic          lane_sel;
    logic [1:0]    lane_step;
    logic [1:0]    lane_old;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_step[g] = in_valid && (lane_sel == 1'(g));
        pr4_dicode_lane #(.SW(SW), .MW(MW), .DEPTH(DEPTH), .LEVEL(LEVEL)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .step   (lane_step[g]),
            .sample (in_sample),
            .oldest (lane_old[g])
        );
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:   if (in_valid && fill_cnt == CW'(FILL_N - 1)) state_nx = ST_STREAM;
            ST_STREAM: state_nx = ST_STREAM;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
            lane_sel <= 1'b0;
        end else begin
            state <= state_nx;
            if (in_valid) begin
                lane_sel <= ~lane_sel;
                if (state == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    // Outputs: the switch follows the lane fed by this sample
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= in_valid && (state == ST_STREAM);
            if (in_valid) out_bit <= lane_old[lane_sel];
        end
    end

    assert_one_lane_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $countones(lane_step) == 1);

    assert_alternate_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_step[0]) |=> (in_valid -> lane_step[1]));

    assert_valid_source_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid) && $past(state == ST_STREAM));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: tb/tb_pr4_ilv_viterbi.sv
module tb_pr4_ilv_viterbi;
    localparam int SW    = 8;
    localparam int MW    = 12;
    localparam int DEPTH = 8;
    localparam int LEVEL = 24;
    localparam int LAT   = 2 * DEPTH;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst;
    logic                 in_valid;
    logic signed [SW-1:0] in_sample;
    logic                 out_valid;
    logic                 out_bit;

    pr4_ilv_viterbi #(.SW(SW), .MW(MW), .DEPTH(DEPTH), .LEVEL(LEVEL)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    int    total = 0;
    int    bad   = 0;
    int    n     = 0;
    bit    hist [0:4095];
    bit    exp_v, exp_b, exp_live;
    string exp_tag, vtag;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Apply one cycle of stimulus; compare the previous cycle's expectation first
    task automatic cyc(input bit v, input bit b, input int noise, input string req);
        int prv, y;
        @(negedge clk);
        if (exp_live) begin
            check(out_valid == exp_v, vtag, int'(out_valid), int'(exp_v));
            if (exp_v) check(out_bit == exp_b, exp_tag, int'(out_bit), int'(exp_b));
        end
        in_valid = v;
        if (v) begin
            hist[n] = b;
            prv = (n >= 2) ? int'(hist[n-2]) : 0;
            y = LEVEL * (int'(b) - prv) + noise;
            in_sample = SW'(y);
            exp_v = (n >= LAT);
            exp_b = (n >= LAT) ? hist[n-LAT] : 1'b0;
            vtag = "R3";
            n++;
        end else begin
            in_sample = SW'($urandom);
            exp_v = 1'b0;
            vtag = "R6";
        end
        exp_tag  = req;
        exp_live = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        exp_live = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        rst = 1'b0;
        n = 0;
    endtask

    function automatic int noise3();
        return int'($urandom_range(6)) - 3;
    endfunction

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; in_valid = 1'b0; in_sample = '0; exp_live = 1'b0;
        exp_v = 1'b0; exp_b = 1'b0; exp_tag = "R4"; vtag = "R3";

        // All zeros: tie handling keeps state 0
        do_reset();
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 0, "R8");

        // All ones
        do_reset();
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1, 0, "R4");

        // Even bits 1, odd bits 0: interleave and re-merge order
        do_reset();
        for (int i = 0; i < 64; i++) cyc(1'b1, ((i % 2) == 0), 0, "R2");

        // Random noiseless stream
        do_reset();
        for (int i = 0; i < 600; i++) cyc(1'b1, 1'($urandom), 0, "R4");

        // Random noisy stream with idle gaps carrying garbage samples
        do_reset();
        for (int i = 0; i < 1200; i++) begin
            if ($urandom_range(3) == 0) cyc(1'b0, 1'b0, 0, "R6");
            else                        cyc(1'b1, 1'($urandom), noise3(), "R5");
        end

        // Reset in the middle of a stream
        do_reset();
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'($urandom), 0, "R9");
        do_reset();
        for (int i = 0; i < 60; i++) cyc(1'b1, 1'($urandom), noise3(), "R9");

        cyc(1'b0, 1'b0, 0, "R6");
        cyc(1'b0, 1'b0, 0, "R6");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule